// File: doc/BRIEF.md
# Boot remap control register

This block is the control register of a processor module, together with the address steering for the module's low boot window. Software reads and writes it through a single-cycle register port. It holds three settings:

- a byte-order bit, which drives the `big_endian` output;
- a remap bit;
- an LED bit.

Writing a 1 to a trigger bit makes the block raise a one-cycle reset request. A live board-attach input is reflected back in the read data.

The steering half looks at every bus address. Addresses inside the first 256 KiB (byte addresses 0x00000000 to 0x0003FFFF) form the boot window. Each such address is sent to exactly one of three targets: boot ROM, flash or SSRAM. The target is picked as follows:

1. When the effective remap is 1, the window goes to SSRAM.
2. Otherwise the boot switch picks the target: switch on selects boot ROM, switch off selects flash.

Remap is effective only while the module is attached to a board (attach input low). A standalone module therefore always boots from ROM or flash, whatever the remap bit holds.

The reset request is produced by a two-state machine. `PULSE_IDLE` moves to `PULSE_FIRE` on a write with the trigger bit set. `PULSE_FIRE` moves back to `PULSE_IDLE` unless another triggering write arrives in that cycle, in which case it stays in `PULSE_FIRE`. The output is high only in `PULSE_FIRE`. The steering uses four target codes: `TGT_NONE`, `TGT_ROM`, `TGT_FLASH` and `TGT_SRAM`.

Top module: `bootmap_ctrl`

## Requirements
- R1: After reset, read data bits 5, 2 and 0 are 0, `big_endian`, `led_on` and `reset_req` are 0, and an in-window address selects ROM or flash per the boot switch.
- R2: Bit 5 is the byte-order bit (0 little, 1 big). It is written by a register write and read back, and it drives `big_endian` from the cycle after the write.
- R3: Bit 0 is the LED bit (1 lit). It is written and read back, and it drives `led_on` from the cycle after the write.
- R4: Bit 2 is the remap bit. It is written and read back.
- R5: A write with bit 3 set raises `reset_req` for exactly the one cycle after the write. Bit 3 always reads as 0.
- R6: Bit 1 reads the current level of `attach_n` (0 attached, 1 standalone). A write to bit 1 has no effect.
- R7: Bits 31:6 and bit 4 read as 0 whatever was written to them.
- R8: When remap is not effective, an address in the boot window asserts `sel_rom` if `boot_sw_on` is 1, and `sel_flash` if it is 0.
- R9: When the remap bit is 1 and `attach_n` is 0, an address in the boot window asserts `sel_sram` only.
- R10: When `attach_n` is 1, the boot window decodes as if remap were 0, even with the remap bit set.
- R11: An address at or above 0x00040000 asserts none of the three selects, and at most one select is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, always valid |
| attach_n | input | 1 | Board attach detect: 0 attached, 1 standalone |
| boot_sw_on | input | 1 | Boot switch: 1 boot ROM, 0 flash |
| bus_addr | input | 32 | Bus byte address to steer |
| sel_rom | output | 1 | Boot ROM select |
| sel_flash | output | 1 | Flash select |
| sel_sram | output | 1 | SSRAM select |
| big_endian | output | 1 | Byte-order setting |
| led_on | output | 1 | LED drive |
| reset_req | output | 1 | One-cycle reset request |

## Verification
A wrong stored setting is visible on `reg_rdata` and on the matching output in the very cycle after the write edge. A wrong remap value also shows at once as SSRAM being selected in place of ROM or flash, or the reverse. A pulse machine stuck in `PULSE_FIRE`, or one that never leaves `PULSE_IDLE`, shows in the cycle after a write as a `reset_req` that is either held high or missing. The bench therefore compares the read data, all three selects and the pulse on every cycle. It toggles the attach and switch inputs so that each way of gating remap gets observed.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;
    localparam int BIT_LED    = 0;
    localparam int BIT_ATTACH = 1;
    localparam int BIT_REMAP  = 2;
    localparam int BIT_RSTREQ = 3;
    localparam int BIT_BIGEND = 5;

    typedef enum logic {
        PULSE_IDLE,
        PULSE_FIRE
    } pulse_state_e;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_ROM,
        TGT_FLASH,
        TGT_SRAM
    } boot_tgt_e;
endpackage

// File: rtl/bootmap_regs.sv
module bootmap_regs
    import bootmap_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              attach_n,
    output logic              big_end,
    output logic              remap,
    output logic              led,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            big_end <= 1'b0;
            remap   <= 1'b0;
            led     <= 1'b0;
        end else if (we) begin
            big_end <= wdata[BIT_BIGEND];
            remap   <= wdata[BIT_REMAP];
            led     <= wdata[BIT_LED];
        end
    end

    always_comb begin
        rdata             = '0;
        rdata[BIT_BIGEND] = big_end;
        rdata[BIT_REMAP]  = remap;
        rdata[BIT_ATTACH] = attach_n;
        rdata[BIT_LED]    = led;
    end

    p_write_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (big_end == $past(wdata[BIT_BIGEND])));
    p_write_led_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (led == $past(wdata[BIT_LED])));
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(remap));
    p_attach_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[BIT_ATTACH] == attach_n);
    p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[DATA_W-1:6] == '0) && !rdata[4] && !rdata[BIT_RSTREQ]);
endmodule

// File: rtl/bootmap_pulse.sv
module bootmap_pulse
    import bootmap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic trig_bit,
    output logic reset_req
);
    pulse_state_e state_q, state_d;
    logic         fire;

    assign fire = we && trig_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PULSE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PULSE_IDLE: if (fire)  state_d = PULSE_FIRE;
            PULSE_FIRE: if (!fire) state_d = PULSE_IDLE;
            default:               state_d = PULSE_IDLE;
        endcase
    end

    always_comb begin
        reset_req = 1'b0;
        unique case (state_q)
            PULSE_IDLE: reset_req = 1'b0;
            PULSE_FIRE: reset_req = 1'b1;
            default:    reset_req = 1'b0;
        endcase
    end

    p_pulse_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> reset_req);
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !reset_req);
endmodule

// File: rtl/bootmap_decode.sv
module bootmap_decode
    import bootmap_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_LOG2 = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              remap,
    input  logic              attach_n,
    input  logic              boot_sw_on,
    output logic              sel_rom,
    output logic              sel_flash,
    output logic              sel_sram
);
    localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(1) << WIN_LOG2;

    logic      in_win;
    logic      remap_eff;
    boot_tgt_e tgt;

    assign in_win    = (addr[ADDR_W-1:WIN_LOG2] == '0);
    assign remap_eff = remap && !attach_n;

    always_comb begin
        if (!in_win)        tgt = TGT_NONE;
        else if (remap_eff) tgt = TGT_SRAM;
        else if (boot_sw_on) tgt = TGT_ROM;
        else                tgt = TGT_FLASH;
    end

    always_comb begin
        sel_rom   = 1'b0;
        sel_flash = 1'b0;
        sel_sram  = 1'b0;
        unique case (tgt)
            TGT_NONE:  ;
            TGT_ROM:   sel_rom   = 1'b1;
            TGT_FLASH: sel_flash = 1'b1;
            TGT_SRAM:  sel_sram  = 1'b1;
            default:   ;
        endcase
    end

    p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_rom, sel_flash, sel_sram}));
    p_outside_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= WIN_END) |-> !(sel_rom || sel_flash || sel_sram));
    p_standalone_r10: assert property (@(posedge clk) disable iff (!rst_n)
        attach_n |-> !sel_sram);
    p_switch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr < WIN_END && !remap) |-> (sel_rom == boot_sw_on && sel_flash == !boot_sw_on));
endmodule

// File: rtl/bootmap_ctrl.sv
module bootmap_ctrl
    import bootmap_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int WIN_LOG2 = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              attach_n,
    input  logic              boot_sw_on,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              sel_rom,
    output logic              sel_flash,
    output logic              sel_sram,
    output logic              big_endian,
    output logic              led_on,
    output logic              reset_req
);
    logic remap_q;

    bootmap_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .wdata    (reg_wdata),
        .attach_n (attach_n),
        .big_end  (big_endian),
        .remap    (remap_q),
        .led      (led_on),
        .rdata    (reg_rdata)
    );

    bootmap_pulse u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .trig_bit  (reg_wdata[BIT_RSTREQ]),
        .reset_req (reset_req)
    );

    bootmap_decode #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (bus_addr),
        .remap      (remap_q),
        .attach_n   (attach_n),
        .boot_sw_on (boot_sw_on),
        .sel_rom    (sel_rom),
        .sel_flash  (sel_flash),
        .sel_sram   (sel_sram)
    );

    p_sram_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_sram) |-> (reg_rdata[BIT_REMAP] && !reg_rdata[BIT_ATTACH]));
endmodule

// File: tb/bootmap_ctrl_tb.sv
`timescale 1ns/1ps
module bootmap_ctrl_tb_top;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        attach_n = 1'b0;
    logic        boot_sw_on = 1'b1;
    logic [31:0] bus_addr = '0;
    logic        sel_rom, sel_flash, sel_sram, big_endian, led_on, reset_req;

    always #HALF clk = ~clk;

    bootmap_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .attach_n(attach_n), .boot_sw_on(boot_sw_on),
        .bus_addr(bus_addr), .sel_rom(sel_rom), .sel_flash(sel_flash),
        .sel_sram(sel_sram), .big_endian(big_endian), .led_on(led_on),
        .reset_req(reset_req)
    );

    typedef struct packed {
        logic [31:0] rdata;
        logic [2:0]  sel;
        logic        big;
        logic        led;
        logic        rst;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    event  ev_chk;
    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;

    logic m_big = 1'b0, m_remap = 1'b0, m_led = 1'b0, m_pulse = 1'b0;

    // monitor: pops the oldest expectation and compares it with the ports
    initial begin
        forever begin
            @(ev_chk);
            while (exp_q.size() > 0) begin
                exp_t  e;
                exp_t  a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {reg_rdata, {sel_rom, sel_flash, sel_sram}, big_endian, led_on, reset_req};
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s: actual rdata=%h sel=%b big=%b led=%b rst=%b expected rdata=%h sel=%b big=%b led=%b rst=%b",
                             t, a.rdata, a.sel, a.big, a.led, a.rst,
                             e.rdata, e.sel, e.big, e.led, e.rst);
                end
            end
        end
    end

    // driver: one cycle of stimulus plus its expected result from the model
    task automatic cycle(input logic we, input logic [31:0] wd, input logic [31:0] addr,
                         input logic att, input logic sw, input string tag);
        exp_t e;
        @(negedge clk);
        reg_we = we; reg_wdata = wd; bus_addr = addr; attach_n = att; boot_sw_on = sw;
        #2;
        e.rdata = {26'd0, m_big, 1'b0, 1'b0, m_remap, att, m_led};
        if (addr >= 32'h0004_0000)  e.sel = 3'b000;
        else if (m_remap && !att)   e.sel = 3'b001;
        else if (sw)                e.sel = 3'b100;
        else                        e.sel = 3'b010;
        e.big = m_big; e.led = m_led; e.rst = m_pulse;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        ->ev_chk;
        m_pulse = we && wd[3];
        if (we) begin
            m_big = wd[5]; m_remap = wd[2]; m_led = wd[0];
        end
    endtask

    initial begin
        #(2 * HALF * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cycle(0, 32'h0, 32'h0000_0100, 0, 1, "R1 reset defaults rom");
        cycle(0, 32'h0, 32'h0000_0100, 0, 0, "R1 reset defaults flash");
        // write all ones: sets byte order, remap, LED, trigger; reserved ignored
        cycle(1, 32'hFFFF_FFFF, 32'h0000_0000, 0, 1, "R5 write trigger");
        cycle(0, 32'h0, 32'h0000_0000, 0, 1, "R5 pulse high, R7 reserved zero, R9 sram");
        cycle(0, 32'h0, 32'h0003_FFFF, 0, 0, "R5 pulse ends, R9 top of window");
        cycle(0, 32'h0, 32'h0004_0000, 0, 1, "R11 first address outside window");
        cycle(0, 32'h0, 32'hC200_0000, 0, 1, "R11 far address");
        cycle(0, 32'h0, 32'h0000_1000, 1, 1, "R10 standalone rom, R6 attach reads 1");
        cycle(0, 32'h0, 32'h0000_1000, 1, 0, "R10 standalone flash");
        cycle(1, 32'h0000_0000, 32'h0000_2000, 0, 1, "R4 clear all");
        cycle(0, 32'h0, 32'h0000_2000, 0, 1, "R8 switch on rom");
        cycle(0, 32'h0, 32'h0000_2000, 0, 0, "R8 switch off flash");
        cycle(1, 32'h0000_0020, 32'h0, 0, 1, "R2 write byte order");
        cycle(0, 32'h0, 32'h0, 0, 1, "R2 byte order read back");
        cycle(1, 32'h0000_0001, 32'h0, 0, 1, "R3 write LED");
        cycle(0, 32'h0, 32'h0, 0, 1, "R3 LED read back");
        cycle(1, 32'h0000_0004, 32'h10, 0, 0, "R4 write remap");
        cycle(0, 32'h0, 32'h10, 0, 0, "R4 remap read back sram");
        cycle(1, 32'h0000_0002, 32'h10, 0, 0, "R6 write attach bit");
        cycle(0, 32'h0, 32'h10, 0, 0, "R6 attach bit unaffected");
        cycle(1, 32'hFFFF_FFD0, 32'h10, 0, 1, "R7 write reserved only");
        cycle(0, 32'h0, 32'h10, 0, 1, "R7 reserved still zero");
        cycle(1, 32'h0000_0008, 32'h10, 0, 1, "R5 trigger only");
        cycle(1, 32'h0000_0008, 32'h10, 0, 1, "R5 back to back trigger");
        cycle(0, 32'h0, 32'h10, 0, 1, "R5 second pulse");
        cycle(0, 32'h0, 32'h10, 0, 1, "R5 idle again");
        @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule